// File: doc/BRIEF.md
# Prescaled Interval Timer with Interrupt Modes

This block is a 32-bit up-counter driven from the system clock through a selectable prescaler. Its count is compared with a programmable target. An interrupt event is raised when the count reaches the target, when it wraps from all-ones to zero, or on either of the two. A single interrupt flag is held at bit 10 of the control word and is active low. It can fire once (one-shot) or on every event (repeat). It can also drop for a fixed short window (pulse) or invert on each event (toggle).

Software reaches three words through a simple register port: control, count and target. Writes take effect at the next clock edge and reads are combinational. The low three control bits form a gate code that this block does not implement. The two codes that would hold the counter under a gate park it instead. A target written at or below the live count is held back until the counter has wrapped once, so a late write does not raise an immediate match.

Top module: `presc_timer`

## Requirements
- R1: Control bits [14:13] select the prescaler: 00 increments every cycle, 01 every 8th, 10 every 16th, 11 every 256th. After a control write the first increment lands on the divisor-th edge that follows.
- R2: A control write stores bits [15:0] (bit 10 excepted), clears the count, the prescaler phase and any held-back target, and sets bit 10 high (inactive).
- R3: A gate code of 001 or 111 in control bits [2:0] parks the counter, which then never increments. Every other code counts normally.
- R4: With control bit 4 set, the count stepping onto the target value is an interrupt event.
- R5: With control bit 5 set, the count stepping from all-ones to zero is an interrupt event.
- R6: In repeat pulse mode (bit 6 = 1, bit 7 = 0), an event drives bit 10 low for exactly 4 cycles, after which it returns high by itself.
- R7: In repeat toggle mode (bit 6 = 1, bit 7 = 1), each event inverts bit 10, and the level holds between events.
- R8: In one-shot mode (bit 6 = 0), only the first event after a control write drives bit 10 low. Later events never drive it low again until the next control write.
- R9: A target written with a value less than or equal to the current count produces no match until the counter has wrapped once.
- R10: A count write loads the value exactly and has priority over an increment in the same cycle. It leaves the prescaler phase untouched.
- R11: A target write sets bit 10 high when bit 7 is clear. It leaves bit 10 unchanged when bit 7 is set.
- R12: Register addresses are 0 = control (bit 10 reads the flag), 1 = count, 2 = target, and 3 reads zero. The irq output is the inverse of bit 10. Reset leaves control at 0x400, count 0 and target 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Word selected for writing |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word selected for reading |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt, high while bit 10 is low |

## Verification
Every write lands on the edge that follows the strobe. At divide-by-1 the count seen after N further edges is the loaded value plus N, and an event appears in bit 10 and irq on the same edge that moves the count onto the target or through zero. A pulse releases on the fourth edge after the event edge. The bench drives and samples only on falling edges and counts whole edges from the write. It therefore checks each count, flag set and flag release on the exact edge where it is due, and checks the preceding edge as well.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_TARGET = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  localparam int CTRL_W     = 16;
  localparam int PHASE_W    = 8;
  localparam int B_TGT_EN   = 4;
  localparam int B_OVF_EN   = 5;
  localparam int B_REPEAT   = 6;
  localparam int B_TOGGLE   = 7;
  localparam int B_FLAG     = 10;
  localparam int B_DIV_LO   = 13;

  // last phase value before an increment, per divider code
  function automatic logic [PHASE_W-1:0] phase_last(input logic [1:0] sel);
    case (sel)
      2'b00:   phase_last = PHASE_W'(0);
      2'b01:   phase_last = PHASE_W'(7);
      2'b10:   phase_last = PHASE_W'(15);
      default: phase_last = PHASE_W'(255);
    endcase
  endfunction

  // gate codes that would hold the counter under a gate: park instead
  function automatic logic parks(input logic [2:0] gate_code);
    parks = (gate_code == 3'b001) || (gate_code == 3'b111);
  endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);

  logic [PHASE_W-1:0] phase_q;

  assign tick = run && (phase_q == phase_last(div_sel));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/ptmr_irq_flag.sv
module ptmr_irq_flag #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic tgt_wr,
  input  logic evt,
  input  logic repeat_en,
  input  logic toggle_en,
  output logic flag,
  output logic fired
);

  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic [PC_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_wr) begin
      flag   <= 1'b1;
      fired  <= 1'b0;
      hold_q <= '0;
    end else if (evt && !fired) begin
      if (!repeat_en) begin
        flag  <= 1'b0;
        fired <= 1'b1;
      end else if (toggle_en) begin
        flag <= ~flag;
      end else begin
        flag   <= 1'b0;
        hold_q <= PC_W'(PULSE_LEN - 1);
      end
    end else if (tgt_wr && !toggle_en) begin
      flag   <= 1'b1;
      hold_q <= '0;
    end else if (!flag && repeat_en && !toggle_en) begin
      if (hold_q == '0) flag <= 1'b1;
      else              hold_q <= hold_q - 1'b1;
    end
  end

endmodule

// File: rtl/presc_timer.sv
module presc_timer
  import ptmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] target_q;
  logic              held_q;

  logic ctrl_wr, cnt_wr, tgt_wr;
  logic stopped, tick, inc, wrap, hit, evt, flag, fired;
  logic repeat_en, toggle_en;
  logic [DATA_W-1:0] count_nx;

  assign ctrl_wr   = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
  assign cnt_wr    = wr_en && (reg_sel_e'(wr_addr) == REG_COUNT);
  assign tgt_wr    = wr_en && (reg_sel_e'(wr_addr) == REG_TARGET);
  assign stopped   = parks(ctrl_q[2:0]);
  assign repeat_en = ctrl_q[B_REPEAT];
  assign toggle_en = ctrl_q[B_TOGGLE];

  ptmr_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl_wr),
    .run     (!stopped),
    .div_sel (ctrl_q[B_DIV_LO+1:B_DIV_LO]),
    .tick    (tick)
  );

  // named events for the checker
  assign inc      = tick && !cnt_wr && !ctrl_wr;
  assign count_nx = count_q + 1'b1;
  assign wrap     = inc && (count_q == ALL_ONES);
  assign hit      = inc && (!held_q || wrap) && (count_nx == target_q);
  assign evt      = (hit && ctrl_q[B_TGT_EN]) || (wrap && ctrl_q[B_OVF_EN]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      count_q  <= '0;
      target_q <= '0;
      held_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q         <= wr_data[CTRL_W-1:0];
        ctrl_q[B_FLAG] <= 1'b0;
        count_q        <= '0;
      end else if (cnt_wr) begin
        count_q <= wr_data;
      end else if (inc) begin
        count_q <= count_nx;
      end

      if (tgt_wr) target_q <= wr_data;

      if (ctrl_wr)     held_q <= 1'b0;
      else if (tgt_wr) held_q <= (wr_data <= count_q);
      else if (wrap)   held_q <= 1'b0;
    end
  end

  ptmr_irq_flag #(.PULSE_LEN(PULSE_LEN)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .tgt_wr    (tgt_wr),
    .evt       (evt),
    .repeat_en (repeat_en),
    .toggle_en (toggle_en),
    .flag      (flag),
    .fired     (fired)
  );

  assign irq = ~flag;

  always_comb begin
    logic [CTRL_W-1:0] ctrl_view;
    ctrl_view         = ctrl_q;
    ctrl_view[B_FLAG] = flag;
    case (reg_sel_e'(rd_addr))
      REG_CTRL:   rd_data = DATA_W'(ctrl_view);
      REG_COUNT:  rd_data = count_q;
      REG_TARGET: rd_data = target_q;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic              cnt_wr,
  input logic              tgt_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] count_q,
  input logic              flag,
  input logic              evt,
  input logic              stopped,
  input logic              repeat_en,
  input logic              toggle_en
);

  // R2
  ctrl_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (count_q == '0) && flag);

  // R3
  parked_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !cnt_wr && !ctrl_wr) |=> $stable(count_q));

  // R7
  toggle_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && repeat_en && toggle_en && !ctrl_wr) |=> (flag != $past(flag)));

  // R8
  oneshot_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!repeat_en && !flag && !ctrl_wr && !tgt_wr) |=> !flag);

  // R10
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(wr_data)));

endmodule

bind presc_timer ptmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_wr   (ctrl_wr),
  .cnt_wr    (cnt_wr),
  .tgt_wr    (tgt_wr),
  .wr_data   (wr_data),
  .count_q   (count_q),
  .flag      (flag),
  .evt       (evt),
  .stopped   (stopped),
  .repeat_en (repeat_en),
  .toggle_en (toggle_en)
);

// File: tb/presc_timer_test.sv
module presc_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_TGT = 2'd2, A_NONE = 2'd3;

  always #5 clk = ~clk;

  presc_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // write lands on the next rising edge; returns on the falling edge after it
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); chk("R12 reset ctrl", v, 32'h400);
    rd(A_CNT, v);  chk("R12 reset count", v, 0);
    rd(A_TGT, v);  chk("R12 reset target", v, 0);
    chk("R12 reset irq", {31'b0, irq}, 0);
  endtask

  task automatic t_prescale(input logic [1:0] sel, input int div, input int n);
    logic [31:0] v;
    wr(A_CTRL, {16'b0, 1'b0, sel, 13'b0});
    edges(n);
    rd(A_CNT, v);
    chk($sformatf("R1 div %0d after %0d", div, n), v, n / div);
    edges(div - 1 - (n % div));
    rd(A_CNT, v);
    chk($sformatf("R1 div %0d edge before step", div), v, n / div);
    edges(1);
    rd(A_CNT, v);
    chk($sformatf("R1 div %0d step", div), v, n / div + 1);
  endtask

  task automatic t_park;
    logic [31:0] v;
    wr(A_CTRL, 32'h0001); edges(20); rd(A_CNT, v); chk("R3 code 001 parks", v, 0);
    wr(A_CTRL, 32'h0007); edges(20); rd(A_CNT, v); chk("R3 code 111 parks", v, 0);
    wr(A_CTRL, 32'h0003); edges(20); rd(A_CNT, v); chk("R3 code 011 counts", v, 20);
  endtask

  task automatic t_pulse_target;
    logic [31:0] v;
    wr(A_TGT, 32'd10);
    wr(A_CTRL, 32'h0050);
    edges(9);
    chk("R4 no irq before target", {31'b0, irq}, 0);
    edges(1);
    chk("R4 irq on target", {31'b0, irq}, 1);
    rd(A_CTRL, v); chk("R12 flag bit low", v, 32'h0050);
    for (int k = 0; k < 3; k++) begin
      edges(1);
      chk("R6 pulse held", {31'b0, irq}, 1);
    end
    edges(1);
    chk("R6 pulse released", {31'b0, irq}, 0);
  endtask

  task automatic t_toggle_wrap;
    logic [31:0] v;
    wr(A_CTRL, 32'h00E0);
    wr(A_CNT, 32'hFFFF_FFFD);
    rd(A_CNT, v); chk("R10 count load", v, 32'hFFFF_FFFD);
    edges(2);
    chk("R5 no irq before wrap", {31'b0, irq}, 0);
    edges(1);
    chk("R5 irq on wrap", {31'b0, irq}, 1);
    rd(A_CNT, v); chk("R5 count wrapped", v, 0);
    edges(6);
    chk("R7 toggle holds", {31'b0, irq}, 1);
    wr(A_TGT, 32'h1000);
    chk("R11 target write in toggle keeps flag", {31'b0, irq}, 1);
    wr(A_CNT, 32'hFFFF_FFFF);
    chk("R7 before second wrap", {31'b0, irq}, 1);
    edges(1);
    chk("R7 second wrap inverts", {31'b0, irq}, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(A_TGT, 32'd5);
    wr(A_CTRL, 32'h0030);
    edges(5);
    chk("R8 first event", {31'b0, irq}, 1);
    edges(10);
    chk("R8 stays low", {31'b0, irq}, 1);
    wr(A_CNT, 32'hFFFF_FFFE);
    edges(10);
    chk("R8 later events no effect", {31'b0, irq}, 1);
    wr(A_CTRL, 32'h0030);
    rd(A_CTRL, v); chk("R2 ctrl write restores flag", v, 32'h0430);
    rd(A_CNT, v);  chk("R2 ctrl write clears count", v, 0);
    edges(5);
    chk("R8 rearmed by ctrl write", {31'b0, irq}, 1);
    wr(A_TGT, 32'h40);
    chk("R11 target write in pulse sets flag", {31'b0, irq}, 0);
    edges(80);
    chk("R8 no second event", {31'b0, irq}, 0);
  endtask

  task automatic t_held_target;
    logic [31:0] v;
    wr(A_CTRL, 32'h0050);
    wr(A_CNT, 32'h100);
    wr(A_TGT, 32'h100);
    wr(A_CNT, 32'h20);
    edges(240);
    rd(A_CNT, v); chk("R9 count passed target", v, 32'h110);
    chk("R9 held target no match", {31'b0, irq}, 0);
    wr(A_CNT, 32'hFFFF_FFFE);
    edges(257);
    chk("R9 edge before match after wrap", {31'b0, irq}, 0);
    edges(1);
    chk("R9 match after wrap", {31'b0, irq}, 1);
  endtask

  task automatic t_phase_kept;
    logic [31:0] v;
    wr(A_CTRL, 32'h2000);
    edges(5);
    wr(A_CNT, 32'd100);
    edges(1);
    rd(A_CNT, v); chk("R10 no step yet", v, 100);
    edges(1);
    rd(A_CNT, v); chk("R10 phase kept across load", v, 101);
  endtask

  task automatic t_unused_addr;
    logic [31:0] v;
    rd(A_NONE, v); chk("R12 address 3 reads zero", v, 0);
  endtask

  initial begin
    edges(3);
    t_reset;
    rst_n = 1'b1;
    t_prescale(2'b00, 1, 40);
    t_prescale(2'b01, 8, 40);
    t_prescale(2'b10, 16, 40);
    t_prescale(2'b11, 256, 600);
    t_park;
    t_pulse_target;
    t_toggle_wrap;
    t_oneshot;
    t_held_target;
    t_phase_kept;
    t_unused_addr;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule